// File: doc/BRIEF.md
# Per-Pin Input Event Interrupt Unit

This block watches a port of digital input pins and turns selected activity on them into an interrupt request. Every pin passes through a synchroniser, and then an edge detector or a level comparator, depending on how software set up that pin. A pin can react to rising edges, falling edges or both edges. It can also react to a high or a low level. Detected events go into a raw status word that software can always read, whether or not the pin is armed. An arm mask then gates the raw word into a masked status word. The interrupt request is asserted while any masked bit is set.

Software reaches the block through a small word-wide register interface with write strobes and combinational read data. Edge events stay latched until software writes a one to the matching bit of the acknowledge register. Level events are not stored. They show the live input condition, so they drop by themselves once the input leaves the active level.

Top module: `gpio_irq_unit`

Register addresses: 0 sense select, 1 both-edge select, 2 polarity select, 3 arm mask, 4 raw status (read-only), 5 masked status (read-only), 6 acknowledge (write-only, reads 0), 7 unused (reads 0). Bit i of every register belongs to pin i.

## Requirements
- R1: A sense bit of 0 makes its pin edge-sensed. A sense bit of 1 makes it level-sensed.
- R2: On an edge-sensed pin with its both-edge bit clear, polarity 1 latches rising edges and polarity 0 latches falling edges. The opposite edge leaves raw status unchanged.
- R3: On an edge-sensed pin with its both-edge bit set, either edge latches an event, whatever the polarity bit holds.
- R4: On a level-sensed pin, raw status is 1 while the synchronised input equals the polarity bit and 0 otherwise. An acknowledge write does not clear it.
- R5: Raw status (address 4) records events on pins whose arm bit is 0.
- R6: Writing 1 to a bit of the acknowledge register (address 6) clears that pin's latched edge event at the next clock edge. A 0 bit leaves the event set.
- R7: Masked status (address 5) reads raw status AND arm mask (address 3). irqOut is high exactly when some masked bit is 1.
- R8: An event that is pending on an unarmed pin raises irqOut in the cycle after its arm bit is written to 1.
- R9: When a new edge event and an acknowledge write hit the same pin in the same cycle, the event stays set.
- R10: A pin change applied before clock edge k appears in raw status after clock edge k+2: two synchroniser flops, then the status flop. It is not visible after edge k+1.
- R11: After reset every register reads 0 and irqOut is 0. Configuration registers read back what was written. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | NUM_PINS | Asynchronous input pins |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address for writes and reads |
| busWdata | input | NUM_PINS | Write data |
| busRdata | output | NUM_PINS | Combinational read data for busAddr |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with eight pins and a two-flop synchroniser. With two flops, the three-cycle latency in R10 can be checked edge by edge, and eight pins let one word mix edge pins, level pins of both polarities and unarmed pins. Random configuration writes, acknowledge writes and sparse pin toggles switch pins between the sense modes while events are pending. This reaches the mode-switch and same-cycle acknowledge corners that the directed steps only touch once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_SENSE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_BOTH   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_POL    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_ARM    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MASKED = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_ACK    = 3'd6;

  typedef struct packed {
    logic wrSense;
    logic wrBoth;
    logic wrPol;
    logic wrArm;
    logic wrAck;
  } regStrobe_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    if (busWr) begin
      unique case (busAddr)
        ADDR_SENSE: strobe.wrSense = 1'b1;
        ADDR_BOTH:  strobe.wrBoth  = 1'b1;
        ADDR_POL:   strobe.wrPol   = 1'b1;
        ADDR_ARM:   strobe.wrArm   = 1'b1;
        ADDR_ACK:   strobe.wrAck   = 1'b1;
        default:    strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  regStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [ADDR_W-1:0]   rdSel,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] syncPin,
  output logic [NUM_PINS-1:0] rawStatus,
  output logic [NUM_PINS-1:0] senseSel,
  output logic [NUM_PINS-1:0] bothSel,
  output logic [NUM_PINS-1:0] polSel,
  output logic [NUM_PINS-1:0] armMask,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] prevPin;
  logic [NUM_PINS-1:0] rawNext;
  logic [NUM_PINS-1:0] ackVec;
  logic [NUM_PINS-1:0] maskedStatus;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (pinIn),
    .dOut (syncPin)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= '0;
    else       prevPin <= syncPin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseSel <= '0;
      bothSel  <= '0;
      polSel   <= '0;
      armMask  <= '0;
    end else begin
      if (strobe.wrSense) senseSel <= wrData;
      if (strobe.wrBoth)  bothSel  <= wrData;
      if (strobe.wrPol)   polSel   <= wrData;
      if (strobe.wrArm)   armMask  <= wrData;
    end
  end

  assign ackVec = strobe.wrAck ? wrData : '0;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic riseHit, fallHit, edgeHit, levelOn;
      assign riseHit = syncPin[i] & ~prevPin[i];
      assign fallHit = ~syncPin[i] & prevPin[i];
      assign edgeHit = bothSel[i] ? (riseHit | fallHit)
                                  : (polSel[i] ? riseHit : fallHit);
      assign levelOn = ~(syncPin[i] ^ polSel[i]);
      assign rawNext[i] = senseSel[i] ? levelOn
                                      : ((rawStatus[i] & ~ackVec[i]) | edgeHit);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawStatus <= '0;
    else       rawStatus <= rawNext;
  end

  assign maskedStatus = rawStatus & armMask;
  assign irqOut       = |maskedStatus;

  always_comb begin
    unique case (rdSel)
      ADDR_SENSE:  rdData = senseSel;
      ADDR_BOTH:   rdData = bothSel;
      ADDR_POL:    rdData = polSel;
      ADDR_ARM:    rdData = armMask;
      ADDR_RAW:    rdData = rawStatus;
      ADDR_MASKED: rdData = maskedStatus;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  output logic                irqOut
);

  regStrobe_t          strobe;
  logic [NUM_PINS-1:0] syncPin;
  logic [NUM_PINS-1:0] rawStatus;
  logic [NUM_PINS-1:0] senseSel;
  logic [NUM_PINS-1:0] bothSel;
  logic [NUM_PINS-1:0] polSel;
  logic [NUM_PINS-1:0] armMask;

  gpio_irq_ctrl ctrl_i (
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobe    (strobe),
    .wrData    (busWdata),
    .rdSel     (busAddr),
    .rdData    (busRdata),
    .syncPin   (syncPin),
    .rawStatus (rawStatus),
    .senseSel  (senseSel),
    .bothSel   (bothSel),
    .polSel    (polSel),
    .armMask   (armMask),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWr,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [NUM_PINS-1:0] busWdata,
  input logic [NUM_PINS-1:0] syncPin,
  input logic [NUM_PINS-1:0] rawStatus,
  input logic [NUM_PINS-1:0] senseSel,
  input logic [NUM_PINS-1:0] bothSel,
  input logic [NUM_PINS-1:0] polSel,
  input logic [NUM_PINS-1:0] armMask,
  input logic                irqOut
);

  logic [NUM_PINS-1:0] ackVec;
  assign ackVec = (busWr && busAddr == ADDR_ACK) ? busWdata : '0;

  // R6: a latched edge event survives unless acknowledged
  p_edge_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((~rawStatus & $past(rawStatus & ~senseSel & ~ackVec)) == '0));

  // R4: level pins mirror the synchronised level condition
  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (((rawStatus ^ $past(~(syncPin ^ polSel))) & $past(senseSel)) == '0));

  // R2: a rising edge latches on rising-polarity edge pins
  p_rise_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (($past(syncPin) & ~$past(syncPin, 2) & $past(~senseSel & polSel) & ~rawStatus) == '0));

  // R3: either edge latches on both-edge pins
  p_both_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(syncPin) ^ $past(syncPin, 2)) & $past(~senseSel & bothSel) & ~rawStatus) == '0));

  // R9: an edge coinciding with an acknowledge keeps the bit set
  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (($past(syncPin) & ~$past(syncPin, 2) & $past(~senseSel & polSel & ackVec) & ~rawStatus) == '0));

  // R7: no armed raw bit means no request
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStatus & armMask) == '0) |-> !irqOut);

endmodule

bind gpio_irq_unit gpio_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .syncPin   (syncPin),
  .rawStatus (rawStatus),
  .senseSel  (senseSel),
  .bothSel   (bothSel),
  .polSel    (polSel),
  .armMask   (armMask),
  .irqOut    (irqOut)
);

// File: tb/gpio_irq_unit_tb_top.sv
module gpio_irq_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pins = '0;
  logic       busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqOut;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [7:0] mS1 = '0, mS2 = '0, mPrev = '0, mRaw = '0;
  logic [7:0] mSense = '0, mBoth = '0, mPol = '0, mArm = '0;

  always #10 clk = ~clk;

  gpio_irq_unit dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pins),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mSense;
      3'd1: return mBoth;
      3'd2: return mPol;
      3'd3: return mArm;
      3'd4: return mRaw;
      3'd5: return mRaw & mArm;
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelTick(input logic [7:0] pv, input logic w, input logic [2:0] a,
                           input logic [7:0] d);
    logic [7:0] rise, fall, evt, lvl, ack;
    rise = mS2 & ~mPrev;
    fall = ~mS2 & mPrev;
    evt  = (mBoth & (rise | fall)) | (~mBoth & ((mPol & rise) | (~mPol & fall)));
    lvl  = ~(mS2 ^ mPol);
    ack  = (w && a == 3'd6) ? d : 8'h00;
    mRaw  = (mSense & lvl) | (~mSense & ((mRaw & ~ack) | evt));
    mPrev = mS2;
    mS2   = mS1;
    mS1   = pv;
    if (w) begin
      case (a)
        3'd0: mSense = d;
        3'd1: mBoth  = d;
        3'd2: mPol   = d;
        3'd3: mArm   = d;
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic [7:0] pv, input logic w, input logic [2:0] a,
                      input logic [7:0] d);
    pins = pv; busWr = w; busAddr = a; busWdata = d;
    @(posedge clk);
    modelTick(pv, w, a, d);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(pins, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(pins, 1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    busWr = 1'b0; busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic chkReg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic chkIrq(input string tag, input logic exp);
    #1;
    chk(tag, {7'd0, irqOut}, {7'd0, exp});
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    for (int a = 0; a < 8; a++) chkReg("R11 reset value", a[2:0], 8'h00);
    chkIrq("R11 reset irq", 1'b0);

    // R11 readback
    wr(3'd2, 8'hFF);
    chkReg("R11 polarity readback", 3'd2, 8'hFF);
    wr(3'd6, 8'h5A);
    chkReg("R11 ack reads zero", 3'd6, 8'h00);
    chkReg("R11 unused reads zero", 3'd7, 8'h00);

    // R10 latency, R2 rising, R5 unarmed
    step(8'h01, 1'b0, 3'd0, 8'h00);
    chkReg("R10 not after first edge", 3'd4, 8'h00);
    idle(1);
    chkReg("R10 not after second edge", 3'd4, 8'h00);
    idle(1);
    chkReg("R10 R2 R5 raw after third edge", 3'd4, 8'h01);
    chkReg("R7 masked while unarmed", 3'd5, 8'h00);
    chkIrq("R7 irq low unarmed", 1'b0);

    // R8 arm a pending event
    wr(3'd3, 8'h01);
    chkIrq("R8 irq after arming", 1'b1);
    chkReg("R7 masked after arming", 3'd5, 8'h01);

    // R6 acknowledge
    wr(3'd6, 8'hFE);
    chkReg("R6 zero bit keeps event", 3'd4, 8'h01);
    wr(3'd6, 8'h01);
    chkReg("R6 one bit clears event", 3'd4, 8'h00);
    chkIrq("R7 irq drops after ack", 1'b0);

    // R2 falling edge ignored with polarity 1
    step(8'h00, 1'b0, 3'd0, 8'h00);
    idle(3);
    chkReg("R2 falling ignored", 3'd4, 8'h00);

    // R3 both edges override polarity
    wr(3'd1, 8'h02);
    step(8'h02, 1'b0, 3'd0, 8'h00);
    idle(3);
    chkReg("R3 rising on both-edge pin", 3'd4, 8'h02);
    wr(3'd6, 8'hFF);
    step(8'h00, 1'b0, 3'd0, 8'h00);
    idle(3);
    chkReg("R3 falling on both-edge pin", 3'd4, 8'h02);

    // R2 falling polarity
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd6, 8'hFF);
    step(8'h04, 1'b0, 3'd0, 8'h00);
    idle(3);
    chkReg("R2 rising ignored with polarity 0", 3'd4, 8'h00);
    step(8'h00, 1'b0, 3'd0, 8'h00);
    idle(3);
    chkReg("R2 falling latched with polarity 0", 3'd4, 8'h04);
    wr(3'd6, 8'hFF);

    // R1 R4 level sensing
    wr(3'd2, 8'h08);
    wr(3'd0, 8'h18);
    idle(1);
    chkReg("R1 R4 low-level pin active", 3'd4, 8'h10);
    step(8'h08, 1'b0, 3'd0, 8'h00);
    idle(3);
    chkReg("R4 high-level pin active", 3'd4, 8'h18);
    wr(3'd6, 8'hFF);
    chkReg("R4 ack ignored on level pins", 3'd4, 8'h18);
    step(8'h00, 1'b0, 3'd0, 8'h00);
    idle(3);
    chkReg("R4 level released", 3'd4, 8'h10);

    // R9 edge and ack in the same cycle
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hFF);
    wr(3'd6, 8'hFF);
    chkReg("R6 cleared before R9", 3'd4, 8'h00);
    step(8'h20, 1'b0, 3'd0, 8'h00);
    idle(1);
    wr(3'd6, 8'h20);
    chkReg("R9 edge wins over ack", 3'd4, 8'h20);

    // constrained random against the bench model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] pv, d;
      logic       w;
      logic [2:0] a;
      logic [7:0] v;
      pv = pins;
      if ($urandom % 4 == 0) pv = pv ^ (8'h01 << ($urandom % 8));
      w = ($urandom % 5 == 0);
      a = 3'($urandom % 8);
      d = 8'($urandom);
      step(pv, w, a, d);
      a = 3'($urandom % 8);
      rd(a, v);
      chk("R1 R2 R3 R4 R5 R6 R7 R9 random read", v, modelRead(a));
      chk("R7 R8 random irq", {7'd0, irqOut}, {7'd0, ((mRaw & mArm) != 8'h00)});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule